// File: doc/BRIEF.md
# Edge-Triggered Pin Wake Interrupt Controller

This block watches a small group of external input pins and raises one shared interrupt toward the processor when any enabled pin makes its active transition. Each pin has its own enable bit and its own polarity bit. The polarity bit chooses which transition is active: a falling edge or a rising edge. The same bit also chooses the direction of the pin's pull resistor. A pin that waits for a falling edge is pulled up, and a pin that waits for a rising edge is pulled down. A separate pull-enable bit per pin switches the pull resistor on. Each pin passes through a two-stage synchroniser. A transition is found by comparing the pin's current "active" level with its level one cycle earlier.

Every transition on an enabled pin latches one shared flag. Software clears the flag by writing an acknowledge bit. A mask bit decides whether the flag reaches the interrupt request output. The active level is computed from the enable bit and the polarity bit as well as the pin value. So turning a pin on, or changing its polarity, while the pin already sits at its new active level looks like a transition and sets the flag. Software therefore configures the block while the interrupt is masked, acknowledges the flag, and only then unmasks.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every register reads 0, irq_req is 0, and pull_en and pull_down are 0. Every pin is disabled with polarity 0 (falling edge, pullup).
- R2: Register address 1 holds the per-pin enable bits, address 2 the polarity bits, and address 3 the pull-enable bits. Each sits in bits [3:0], is read/write, and has bits [7:4] reading 0.
- R3: With polarity 0, a high-to-low transition on an enabled pin sets the flag. A low-to-high transition does not.
- R4: With polarity 1, a low-to-high transition on an enabled pin sets the flag. A high-to-low transition does not.
- R5: Transitions on a pin whose enable bit is 0 never set the flag.
- R6: Detection is edge-only. After an acknowledge, a pin held steadily at its active level does not set the flag again.
- R7: Address 0 is the control/status register: bit 0 is the interrupt mask (read/write, 1 = request allowed), bit 1 is the acknowledge, and bit 2 is the flag (read-only). Writing 1 to bit 1 clears the flag, and bit 1 always reads 0.
- R8: When a detected transition and an acknowledge write happen in the same cycle, the flag ends up set.
- R9: irq_req is high exactly when the flag and the mask bit are both 1. The flag still sets while the mask bit is 0.
- R10: The flag is set by enabling a pin that already sits at its active level, or by changing a pin's polarity so that its present level becomes active.
- R11: This sequence never raises irq_req, even when step 4 sets the flag: mask the interrupt, program the polarity, enable the pulls, enable the pins, acknowledge, then unmask.
- R12: pull_en[i] equals pull-enable bit i. pull_down[i] is 1 only when pull-enable bit i and polarity bit i are both 1; otherwise pull_down[i] is 0, and an enabled pull is then a pullup.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous external pins |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_req | output | 1 | Interrupt request to the processor |
| pull_en | output | 4 | Per-pin pull resistor enable to the pads |
| pull_down | output | 4 | Per-pin pull direction (1 = pulldown) |

## Verification
Each polarity is driven with both directions of transition, which separates active edges from inactive ones. Pins are toggled while disabled and held at a level after an acknowledge; these cases separate edge detection from level detection and from ungated detection. A randomly chosen configuration is followed by a single toggle of a random pin, and the result is compared with a computed expectation, which exercises many combinations of enable and polarity. Directed cases cover the following: the spurious flag from enabling a pin or flipping its polarity, an acknowledge that lands in the same cycle as a detection, and the safe configuration order with the mask held.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int unsigned PIN_CNT  = 4;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 2;

    localparam int unsigned CTL_MASK_BIT = 0;
    localparam int unsigned CTL_ACK_BIT  = 1;
    localparam int unsigned CTL_FLAG_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL   = 2'd0,
        ADR_ENABLE = 2'd1,
        ADR_POLAR  = 2'd2,
        ADR_PULL   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic               mask;
        logic               flag;
        logic [PIN_CNT-1:0] pin_en;
        logic [PIN_CNT-1:0] polar;
        logic [PIN_CNT-1:0] pull;
    } regs_t;

    typedef struct packed {
        logic [PIN_CNT-1:0] stage1;
        logic [PIN_CNT-1:0] stage2;
    } sync_t;

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int unsigned N = pinirq_pkg::PIN_CNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_async,
    output logic [N-1:0] pin_sync
);
    logic [N-1:0] s1_d, s1_q, s2_d, s2_q;

    // one two-stage chain per pin
    for (genvar i = 0; i < N; i++) begin : g_chain
        always_comb begin
            s1_d[i] = pin_async[i];
            s2_d[i] = s1_q[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[i] <= 1'b0;
                s2_q[i] <= 1'b0;
            end else begin
                s1_q[i] <= s1_d[i];
                s2_q[i] <= s2_d[i];
            end
        end
    end

    assign pin_sync = s2_q;

endmodule

// File: rtl/pinirq_edge.sv
module pinirq_edge #(
    parameter int unsigned N = pinirq_pkg::PIN_CNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_sync,
    input  logic [N-1:0] pin_en,
    input  logic [N-1:0] polar,
    output logic [N-1:0] edge_vec,
    output logic         edge_any
);
    logic [N-1:0] act_now;
    logic [N-1:0] act_d, act_q;

    // active level folds in enable and polarity, so enabling a pin or
    // flipping its polarity while it sits at the new active level is an edge
    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            act_now[i]  = pin_en[i] & ~(pin_sync[i] ^ polar[i]);
            edge_vec[i] = act_now[i] & ~act_q[i];
        end
    end

    always_comb begin
        act_d    = act_now;
        edge_any = |edge_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
    import pinirq_pkg::*;
#(
    parameter int unsigned N  = PIN_CNT,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          edge_any,
    output logic [DW-1:0] rdata,
    output logic          ack_wr,
    output logic [N-1:0]  pin_en,
    output logic [N-1:0]  polar,
    output logic [N-1:0]  pull,
    output logic          mask,
    output logic          flag,
    output logic          irq
);
    localparam int unsigned PAD_W = DW - N;

    regs_t r_d, r_q;
    logic  sel_ctrl, sel_en, sel_pol, sel_pull;
    logic  unused_hi;

    assign unused_hi = ^wdata[DW-1:N];

    always_comb begin
        sel_ctrl = (addr == ADR_CTRL);
        sel_en   = (addr == ADR_ENABLE);
        sel_pol  = (addr == ADR_POLAR);
        sel_pull = (addr == ADR_PULL);
        ack_wr   = wr & sel_ctrl & wdata[CTL_ACK_BIT];

        r_d = r_q;
        if (wr && sel_ctrl) r_d.mask   = wdata[CTL_MASK_BIT];
        if (wr && sel_en)   r_d.pin_en = wdata[N-1:0];
        if (wr && sel_pol)  r_d.polar  = wdata[N-1:0];
        if (wr && sel_pull) r_d.pull   = wdata[N-1:0];

        // detection outranks acknowledge
        if (edge_any)    r_d.flag = 1'b1;
        else if (ack_wr) r_d.flag = 1'b0;

        rdata = '0;
        unique case (addr)
            ADR_CTRL: begin
                rdata[CTL_MASK_BIT] = r_q.mask;
                rdata[CTL_FLAG_BIT] = r_q.flag;
            end
            ADR_ENABLE: rdata = {{PAD_W{1'b0}}, r_q.pin_en};
            ADR_POLAR:  rdata = {{PAD_W{1'b0}}, r_q.polar};
            ADR_PULL:   rdata = {{PAD_W{1'b0}}, r_q.pull};
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pin_en = r_q.pin_en;
    assign polar  = r_q.polar;
    assign pull   = r_q.pull;
    assign mask   = r_q.mask;
    assign flag   = r_q.flag;
    assign irq    = r_q.flag & r_q.mask;

endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
    import pinirq_pkg::*;
#(
    parameter int unsigned N  = PIN_CNT,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pin_in,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_req,
    output logic [N-1:0]  pull_en,
    output logic [N-1:0]  pull_down
);
    logic [N-1:0] pin_s;
    logic [N-1:0] en_w, pol_w, pull_w, edge_vec_w;
    logic         edge_any_w, ack_wr_w, mask_w, flag_w;

    pinirq_sync #(.N(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(pin_in),
        .pin_sync (pin_s)
    );

    pinirq_edge #(.N(N)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_sync(pin_s),
        .pin_en  (en_w),
        .polar   (pol_w),
        .edge_vec(edge_vec_w),
        .edge_any(edge_any_w)
    );

    pinirq_regs #(.N(N), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .edge_any(edge_any_w),
        .rdata   (reg_rdata),
        .ack_wr  (ack_wr_w),
        .pin_en  (en_w),
        .polar   (pol_w),
        .pull    (pull_w),
        .mask    (mask_w),
        .flag    (flag_w),
        .irq     (irq_req)
    );

    logic unused_vec;
    assign unused_vec = ^edge_vec_w;

    assign pull_en   = pull_w;
    assign pull_down = pull_w & pol_w;

endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker #(
    parameter int unsigned N = pinirq_pkg::PIN_CNT
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctrl_sel,
    input logic         ack_rd,
    input logic         ack_wr,
    input logic         edge_any,
    input logic         flag,
    input logic         mask,
    input logic         irq,
    input logic [N-1:0] pin_en
);
    // R7: acknowledge without detection clears the flag
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !edge_any) |=> !flag);

    // R7: acknowledge bit never reads back as 1
    assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel |-> !ack_rd);

    // R8: detection wins over a same-cycle acknowledge
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_any |=> flag);

    // R6: with no detection and no acknowledge the flag holds
    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_any && !ack_wr) |=> $stable(flag));

    // R9: masked flag never reaches the request
    assert_mask_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask |-> !irq);

    // R5: with no pin enabled nothing is detected
    assert_no_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en == '0) |-> !edge_any);

endmodule

bind pinirq_ctrl pinirq_checker #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_sel(reg_addr == 2'd0),
    .ack_rd  (reg_rdata[1]),
    .ack_wr  (ack_wr_w),
    .edge_any(edge_any_w),
    .flag    (flag_w),
    .mask    (mask_w),
    .irq     (irq_req),
    .pin_en  (en_w)
);

// File: tb/tb_pinirq_ctrl.sv
module tb_pinirq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] pin_in = '1;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [N-1:0] pull_en, pull_down;

    int n_chk = 0;
    int n_fail = 0;
    bit irq_mon = 1'b0;
    bit irq_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .pull_en(pull_en), .pull_down(pull_down)
    );

    always @(posedge clk) if (irq_mon && irq_req) irq_seen = 1'b1;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic bit flag_of(logic [7:0] c);
        return c[2];
    endfunction

    // expected detection for one toggle with stable configuration
    function automatic bit exp_set(bit en, bit pol, bit old_v, bit new_v);
        if (!en) return 1'b0;
        return pol ? (!old_v && new_v) : (old_v && !new_v);
    endfunction

    task automatic ack_settle();
        wr(2'd0, 8'h02);
        tick(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 reset rdata", d, 0);
        end
        check("R1 irq", irq_req, 0);
        check("R1 pull_en", pull_en, 0);
        check("R1 pull_down", pull_down, 0);

        // R2 register read/write
        wr(2'd1, 8'hF5); rd(2'd1, d); check("R2 enable", d, 8'h05);
        wr(2'd2, 8'hAA); rd(2'd2, d); check("R2 polarity", d, 8'h0A);
        wr(2'd3, 8'h3C); rd(2'd3, d); check("R2 pull", d, 8'h0C);
        // R12 pull outputs
        check("R12 pull_en", pull_en, 4'hC);
        check("R12 pull_down", pull_down, 4'h8);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        tick(4); ack_settle();

        // R3 polarity 0, pin 0 idle high
        pin_in = 4'hF;
        wr(2'd1, 8'h01); tick(4); ack_settle();
        pin_in[0] = 1'b0; tick(4);
        rd(2'd0, d); check("R3 falling sets", flag_of(d), 1);
        check("R9 masked irq low", irq_req, 0);
        ack_settle();
        rd(2'd0, d); check("R7 ack clears", flag_of(d), 0);
        check("R7 ack reads 0", d[1], 0);
        pin_in[0] = 1'b1; tick(4);
        rd(2'd0, d); check("R3 rising ignored", flag_of(d), 0);

        // R6 held level after ack
        pin_in[0] = 1'b0; tick(4); ack_settle(); tick(6);
        rd(2'd0, d); check("R6 held level no reset", flag_of(d), 0);
        pin_in[0] = 1'b1; tick(4);

        // R4 polarity 1 on pin 1
        pin_in[1] = 1'b0;
        wr(2'd2, 8'h02); wr(2'd1, 8'h02); tick(4); ack_settle();
        pin_in[1] = 1'b1; tick(4);
        rd(2'd0, d); check("R4 rising sets", flag_of(d), 1);
        ack_settle();
        pin_in[1] = 1'b0; tick(4);
        rd(2'd0, d); check("R4 falling ignored", flag_of(d), 0);

        // R5 disabled pins
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); tick(4); ack_settle();
        pin_in = 4'h0; tick(4); pin_in = 4'hF; tick(4); pin_in = 4'h0; tick(4);
        rd(2'd0, d); check("R5 disabled no flag", flag_of(d), 0);

        // R10 enabling at active level (pol 0, pin low)
        wr(2'd1, 8'h04); tick(2);
        rd(2'd0, d); check("R10 enable spurious", flag_of(d), 1);
        pin_in = 4'hF; tick(4); ack_settle();
        // R10 polarity flip with pin high
        wr(2'd2, 8'h04); tick(2);
        rd(2'd0, d); check("R10 polarity spurious", flag_of(d), 1);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); tick(4); ack_settle();

        // R9 mask gating
        wr(2'd1, 8'h08); tick(4); ack_settle();
        pin_in[3] = 1'b0; tick(4);
        check("R9 flag set masked irq", irq_req, 0);
        wr(2'd0, 8'h01); tick(1);
        check("R9 unmasked irq", irq_req, 1);
        wr(2'd0, 8'h03); tick(1);
        check("R9 irq after ack", irq_req, 0);
        wr(2'd0, 8'h00);
        pin_in[3] = 1'b1; tick(4);
        wr(2'd1, 8'h00); tick(4); ack_settle();

        // R8 detection and ack in same cycle on pin 2
        wr(2'd1, 8'h04); tick(4); ack_settle();
        pin_in[2] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h02; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd(2'd0, d); check("R8 set wins over ack", flag_of(d), 1);
        pin_in[2] = 1'b1; tick(4);
        wr(2'd1, 8'h00); tick(4); ack_settle();

        // R11 safe init order, pin 0 held low to provoke a spurious set
        pin_in = 4'hE;
        irq_seen = 1'b0; irq_mon = 1'b1;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h0F);
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h02);
        wr(2'd0, 8'h01);
        tick(6);
        irq_mon = 1'b0;
        check("R11 no irq during init", irq_seen, 0);
        check("R12 pullups", {pull_en, pull_down}, 8'hF0);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h00);
        pin_in = 4'hF; tick(4); ack_settle();

        // random configurations with a single toggle
        for (int it = 0; it < 300; it++) begin
            logic [3:0] en, pol, pins;
            int p;
            bit nv, e;
            en   = 4'($urandom);
            pol  = 4'($urandom);
            pins = 4'($urandom);
            p    = int'($urandom % 4);
            pin_in = pins;
            wr(2'd2, {4'h0, pol});
            wr(2'd1, {4'h0, en});
            tick(4); ack_settle();
            nv = ~pins[p];
            e  = exp_set(en[p], pol[p], pins[p], nv);
            pin_in[p] = nv;
            tick(4);
            rd(2'd0, d);
            check(e ? "R3/R4 random set" : "R5/R6 random no set", flag_of(d), e);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule